// File: doc/BRIEF.md
# Flash Read-Path Responder

This block decides what a host read of a parallel NOR flash returns. The command decoder reports the current command mode. Depending on that mode, the returned word is one of these: array contents assembled from the storage bytes, an identifier word, a query-table byte, a constant zero, or the device status byte. The block computes the storage address from the host address. The storage answers on `arr_data` in the same cycle, and the selected word appears on `rd_data` one clock after the read strobe.

The block also tracks whether the device sits in direct array-read mode. A write while the decoder is idle takes the device out of that mode. After that, reads that arrive while the decoder has no command in progress are counted. The read that pushes the count past `LAZY_LIMIT` (42 by default, so the 43rd read) puts the device back into array mode. If the command mode is a code the block does not know, the read returns array data and the block tells the decoder to return to idle.

Top module: `fl_read_resp`

## Requirements
- R1: The table/identifier index is the low 8 bits of the masked address shifted right by 0, 1 or 2 for a device width `DEV_BYTES` of 1, 2 or 4 (default 2, so byte address 0x1C is index 0x0E and 0x300 is index 0).
- R2: In autoselect mode (code 0x90), index 0 returns `id0`, index 1 returns `id1` and index 2 returns 0, each zero-extended to 32 bits.
- R3: In autoselect mode, index 0x0E returns `id2` and index 0x0F returns `id3`. If the identifier word equals 0x00FF, array data is returned instead.
- R4: In autoselect mode, every other index returns array data.
- R5: In query mode (code 0x98), an index below `TAB_LEN` (77) returns byte `cfg_table[8*idx +: 8]`. Any larger index returns 0.
- R6: In chip-erase (0x10), sector-erase (0x30) and program (0xA0) modes, the read returns `{24'h0, status}`.
- R7: In read mode (0x00) and erase-setup mode (0x80), array data is returned. `arr_data` byte k (bits 8k+7..8k) holds address+k. `rd_size` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes. With `BIG_ENDIAN`=0 the lowest address is the least significant byte. Unused upper bytes are 0.
- R8: Any other mode code returns array data as in R7. It also raises `mode_clear` for exactly the cycle in which that read's data is valid.
- R9: Out of array mode, reads with `cmd_idle` high are counted. The read that takes the count above `LAZY_LIMIT` sets `array_mode`. Reads with `cmd_idle` low are not counted.
- R10: A write (`wr_seen`) clears the read count. If `cmd_idle` is also high, it clears `array_mode`. A write takes priority over a read in the same cycle.
- R11: `arr_addr` equals the low `CHIP_AW` bits of `rd_addr` in the same cycle.
- R12: Reset leaves `rd_valid`=0, `mode_clear`=0, `rd_data`=0, `array_mode`=1 and a zero read count.
- R13: `rd_valid` is high exactly one cycle after `rd_en`. `rd_data` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host byte address |
| rd_size | input | 2 | Access size: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| cmd_mode | input | 8 | Current command mode from the decoder |
| cmd_idle | input | 1 | Decoder has no command sequence in progress |
| wr_seen | input | 1 | A host write happened this cycle |
| id0 | input | 16 | Identifier word at index 0 |
| id1 | input | 16 | Identifier word at index 1 |
| id2 | input | 16 | Identifier word at index 0x0E |
| id3 | input | 16 | Identifier word at index 0x0F |
| cfg_table | input | TAB_LEN*8 | Query table, byte i at bits 8i+7..8i |
| status | input | 8 | Device status byte |
| arr_addr | output | CHIP_AW | Storage byte address (masked) |
| arr_data | input | 32 | Storage bytes at arr_addr..arr_addr+3 |
| rd_data | output | 32 | Registered read word |
| rd_valid | output | 1 | rd_data holds a new read result |
| mode_clear | output | 1 | Request to the decoder to return to idle |
| array_mode | output | 1 | Device is in direct array-read mode |

## Verification
Several properties are checked on every cycle. Status modes return exactly the status byte that was sampled. Query indices past the table return zero. Read strobes and valids line up. `mode_clear` only follows a read. Array mode is only left through an idle-decoder write and only re-entered on the counted read after the limit, and every write clears the count. Only the bench's scenarios can show the rest: the identifier map and its 0x00FF fallback, the byte order and size masking of array data, the exact 43rd-read re-entry, and the restart of the count after a mid-count write. The bench compares all of these against a behavioural model on each clock.

// File: rtl/fl_rd_pkg.sv
`timescale 1ns/1ps
package fl_rd_pkg;
  localparam logic [7:0] MC_READ        = 8'h00;
  localparam logic [7:0] MC_ERASE_SETUP = 8'h80;
  localparam logic [7:0] MC_AUTOSEL     = 8'h90;
  localparam logic [7:0] MC_QUERY       = 8'h98;
  localparam logic [7:0] MC_CHIP_ERASE  = 8'h10;
  localparam logic [7:0] MC_SECT_ERASE  = 8'h30;
  localparam logic [7:0] MC_PROGRAM     = 8'hA0;

  localparam logic [7:0] IDX_ID0   = 8'h00;
  localparam logic [7:0] IDX_ID1   = 8'h01;
  localparam logic [7:0] IDX_ZERO  = 8'h02;
  localparam logic [7:0] IDX_ID2   = 8'h0E;
  localparam logic [7:0] IDX_ID3   = 8'h0F;

  typedef enum logic [2:0] {
    SRC_ARRAY, SRC_ID0, SRC_ID1, SRC_ID2, SRC_ID3, SRC_ZERO, SRC_TABLE, SRC_STATUS
  } rd_src_e;

  function automatic int idx_shift(input int nbytes);
    if (nbytes == 4) return 2;
    if (nbytes == 2) return 1;
    return 0;
  endfunction
endpackage

// File: rtl/fl_src_select.sv
`timescale 1ns/1ps
module fl_src_select import fl_rd_pkg::*; #(
  parameter int TAB_LEN = 77
) (
  input  logic [7:0] mode,
  input  logic [7:0] idx,
  input  logic       id2_blank,
  input  logic       id3_blank,
  output rd_src_e    src,
  output logic       unknown
);
  always_comb begin
    unknown = 1'b0;
    src     = SRC_ARRAY;
    case (mode)
      MC_READ, MC_ERASE_SETUP: src = SRC_ARRAY;
      MC_AUTOSEL: begin
        case (idx)
          IDX_ID0:  src = SRC_ID0;
          IDX_ID1:  src = SRC_ID1;
          IDX_ZERO: src = SRC_ZERO;
          IDX_ID2:  src = id2_blank ? SRC_ARRAY : SRC_ID2;
          IDX_ID3:  src = id3_blank ? SRC_ARRAY : SRC_ID3;
          default:  src = SRC_ARRAY;
        endcase
      end
      MC_QUERY: src = (int'(idx) < TAB_LEN) ? SRC_TABLE : SRC_ZERO;
      MC_CHIP_ERASE, MC_SECT_ERASE, MC_PROGRAM: src = SRC_STATUS;
      default: begin
        unknown = 1'b1;
        src     = SRC_ARRAY;
      end
    endcase
  end
endmodule

// File: rtl/fl_lane_pack.sv
`timescale 1ns/1ps
module fl_lane_pack #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [1:0]  size,
  input  logic [31:0] raw,
  output logic [31:0] word
);
  logic [7:0] b0, b1, b2, b3;
  assign b0 = raw[7:0];
  assign b1 = raw[15:8];
  assign b2 = raw[23:16];
  assign b3 = raw[31:24];

  generate
    if (BIG_ENDIAN) begin : g_big
      always_comb begin
        case (size)
          2'd0:    word = {24'h0, b0};
          2'd1:    word = {16'h0, b0, b1};
          default: word = {b0, b1, b2, b3};
        endcase
      end
    end else begin : g_little
      always_comb begin
        case (size)
          2'd0:    word = {24'h0, b0};
          2'd1:    word = {16'h0, b1, b0};
          default: word = {b3, b2, b1, b0};
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/fl_romd_track.sv
`timescale 1ns/1ps
module fl_romd_track #(
  parameter int LAZY_LIMIT = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_seen,
  input  logic cmd_idle,
  output logic array_mode
);
  localparam int CW = $clog2(LAZY_LIMIT + 2);
  localparam logic [CW-1:0] LIM = CW'(LAZY_LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      array_mode <= 1'b1;
    end else if (wr_seen) begin
      cnt <= '0;
      if (cmd_idle) array_mode <= 1'b0;
    end else if (rd_en && !array_mode && cmd_idle) begin
      cnt <= cnt + 1'b1;
      if (cnt == LIM) array_mode <= 1'b1;
    end
  end

  // R9: re-entry only on a counted idle read that crosses the limit
  p_reenter_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(array_mode) |-> ($past(rd_en) && $past(cmd_idle) && ($past(cnt) == LIM)));

  // R10: leaving array mode only through an idle-decoder write
  p_leave_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(array_mode) |-> ($past(wr_seen) && $past(cmd_idle)));

  // R10: any write empties the count
  p_wclr_r10: assert property (@(posedge clk) disable iff (rst)
    wr_seen |=> (cnt == '0));
endmodule

// File: rtl/fl_read_resp.sv
`timescale 1ns/1ps
module fl_read_resp import fl_rd_pkg::*; #(
  parameter int ADDR_W     = 24,
  parameter int CHIP_AW    = 16,
  parameter int DEV_BYTES  = 2,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter int TAB_LEN    = 77,
  parameter int LAZY_LIMIT = 42
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [1:0]           rd_size,
  input  logic [7:0]           cmd_mode,
  input  logic                 cmd_idle,
  input  logic                 wr_seen,
  input  logic [15:0]          id0,
  input  logic [15:0]          id1,
  input  logic [15:0]          id2,
  input  logic [15:0]          id3,
  input  logic [TAB_LEN*8-1:0] cfg_table,
  input  logic [7:0]           status,
  output logic [CHIP_AW-1:0]   arr_addr,
  input  logic [31:0]          arr_data,
  output logic [31:0]          rd_data,
  output logic                 rd_valid,
  output logic                 mode_clear,
  output logic                 array_mode
);
  localparam int SHIFT = idx_shift(DEV_BYTES);

  logic [7:0]  idx;
  logic [7:0]  tab_byte;
  logic [31:0] arr_word;
  logic [31:0] nxt_data;
  logic        unknown;
  rd_src_e     src;
  int          tsel;

  assign arr_addr = rd_addr[CHIP_AW-1:0];
  assign idx      = arr_addr[7:0] >> SHIFT;

  always_comb begin
    tsel     = (int'(idx) < TAB_LEN) ? int'(idx) : 0;
    tab_byte = cfg_table[tsel*8 +: 8];
  end

  fl_src_select #(.TAB_LEN(TAB_LEN)) u_sel (
    .mode      (cmd_mode),
    .idx       (idx),
    .id2_blank (id2 == 16'h00FF),
    .id3_blank (id3 == 16'h00FF),
    .src       (src),
    .unknown   (unknown)
  );

  fl_lane_pack #(.BIG_ENDIAN(BIG_ENDIAN)) u_pack (
    .size (rd_size),
    .raw  (arr_data),
    .word (arr_word)
  );

  fl_romd_track #(.LAZY_LIMIT(LAZY_LIMIT)) u_track (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .wr_seen    (wr_seen),
    .cmd_idle   (cmd_idle),
    .array_mode (array_mode)
  );

  always_comb begin
    case (src)
      SRC_ID0:    nxt_data = {16'h0, id0};
      SRC_ID1:    nxt_data = {16'h0, id1};
      SRC_ID2:    nxt_data = {16'h0, id2};
      SRC_ID3:    nxt_data = {16'h0, id3};
      SRC_ZERO:   nxt_data = 32'h0;
      SRC_TABLE:  nxt_data = {24'h0, tab_byte};
      SRC_STATUS: nxt_data = {24'h0, status};
      default:    nxt_data = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      mode_clear <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      mode_clear <= rd_en && unknown;
      if (rd_en) rd_data <= nxt_data;
    end
  end

  // R13: one-cycle read latency
  p_valid_r13: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_novalid_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R8: clear request only accompanies a read result
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    mode_clear |-> rd_valid);

  // R6: status modes return the sampled status byte
  p_status_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (cmd_mode == MC_PROGRAM || cmd_mode == MC_CHIP_ERASE ||
               cmd_mode == MC_SECT_ERASE))
    |=> (rd_data == {24'h0, $past(status)}));

  // R5: query reads past the table are zero
  p_query_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_mode == MC_QUERY && int'(idx) >= TAB_LEN) |=> (rd_data == 32'h0));
endmodule

// File: tb/fl_read_resp_tb.sv
`timescale 1ns/1ps
module fl_read_resp_tb;
  localparam int TAB_LEN = 77;
  localparam int LIMIT   = 42;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               rd_en = 1'b0;
  logic [23:0]        rd_addr = '0;
  logic [1:0]         rd_size = '0;
  logic [7:0]         cmd_mode = '0;
  logic               cmd_idle = 1'b1;
  logic               wr_seen = 1'b0;
  logic [15:0]        id0 = 16'h0001, id1 = 16'h227E, id2 = 16'h2222, id3 = 16'h2201;
  logic [TAB_LEN*8-1:0] cfg_table;
  logic [7:0]         status = 8'h00;
  logic [15:0]        arr_addr;
  logic [31:0]        arr_data;
  logic [31:0]        rd_data;
  logic               rd_valid, mode_clear, array_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [7:0] mb(input int a);
    int m;
    m = a & 16'hFFFF;
    return 8'((m * 13 + (m >> 8) * 5 + 90) & 255);
  endfunction

  function automatic logic [7:0] tb_byte(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] arr_word(input int m, input logic [1:0] sz);
    logic [31:0] w;
    w = {mb(m + 3), mb(m + 2), mb(m + 1), mb(m)};
    if (sz == 2'd0) return w & 32'h0000_00FF;
    if (sz == 2'd1) return w & 32'h0000_FFFF;
    return w;
  endfunction

  always_comb begin
    for (int i = 0; i < TAB_LEN; i++) cfg_table[i*8 +: 8] = tb_byte(i);
  end
  assign arr_data = {mb(int'(arr_addr) + 3), mb(int'(arr_addr) + 2),
                     mb(int'(arr_addr) + 1), mb(int'(arr_addr))};

  fl_read_resp u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .cmd_mode(cmd_mode), .cmd_idle(cmd_idle), .wr_seen(wr_seen),
    .id0(id0), .id1(id1), .id2(id2), .id3(id3), .cfg_table(cfg_table),
    .status(status), .arr_addr(arr_addr), .arr_data(arr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .mode_clear(mode_clear),
    .array_mode(array_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] e_data = '0;
  logic        e_valid = 0, e_clr = 0, e_arr = 1;
  int          e_cnt = 0;
  string       e_tag = "R12";

  always @(posedge clk) begin
    if (rst) begin
      e_data = '0; e_valid = 0; e_clr = 0; e_arr = 1; e_cnt = 0; e_tag = "R12";
    end else begin
      e_valid = rd_en;
      e_clr   = 0;
      if (rd_en) begin
        int m, ix;
        m  = int'(rd_addr) & 16'hFFFF;
        ix = (m & 255) >> 1;
        case (cmd_mode)
          8'h00, 8'h80: begin e_data = arr_word(m, rd_size); e_tag = "R7"; end
          8'h90: begin
            if (ix == 0)      begin e_data = {16'h0, id0}; e_tag = "R2"; end
            else if (ix == 1) begin e_data = {16'h0, id1}; e_tag = "R2"; end
            else if (ix == 2) begin e_data = 0;            e_tag = "R2"; end
            else if (ix == 14) begin
              e_data = (id2 == 16'h00FF) ? arr_word(m, rd_size) : {16'h0, id2}; e_tag = "R3";
            end else if (ix == 15) begin
              e_data = (id3 == 16'h00FF) ? arr_word(m, rd_size) : {16'h0, id3}; e_tag = "R3";
            end else begin e_data = arr_word(m, rd_size); e_tag = "R4"; end
          end
          8'h98: begin
            e_data = (ix < TAB_LEN) ? {24'h0, tb_byte(ix)} : 32'h0; e_tag = "R5";
          end
          8'h10, 8'h30, 8'hA0: begin e_data = {24'h0, status}; e_tag = "R6"; end
          default: begin e_data = arr_word(m, rd_size); e_clr = 1; e_tag = "R8"; end
        endcase
      end
      if (wr_seen) begin
        e_cnt = 0;
        if (cmd_idle) e_arr = 0;
      end else if (rd_en && !e_arr && cmd_idle) begin
        e_cnt++;
        if (e_cnt > LIMIT) e_arr = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R13 rd_valid", 32'(rd_valid), 32'(e_valid));
      chk("R8 mode_clear", 32'(mode_clear), 32'(e_clr));
      chk("R9 R10 array_mode", 32'(array_mode), 32'(e_arr));
      if (e_valid) chk(e_tag, rd_data, e_data);
    end
  end

  // ---------------- stimulus ----------------
  task automatic rd(input logic [23:0] a, input logic [1:0] sz, input logic [7:0] md,
                    input logic idle);
    @(posedge clk); #1;
    rd_en = 1; wr_seen = 0; rd_addr = a; rd_size = sz; cmd_mode = md; cmd_idle = idle;
    @(negedge clk);
    chk("R11 arr_addr", 32'(arr_addr), 32'(a[15:0]));
  endtask

  task automatic wr(input logic idle);
    @(posedge clk); #1;
    rd_en = 0; wr_seen = 1; cmd_idle = idle;
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rd_en = 0; wr_seen = 0; cmd_idle = 1;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 rd_valid", 32'(rd_valid), 0);
    chk("R12 mode_clear", 32'(mode_clear), 0);
    chk("R12 rd_data", rd_data, 0);
    chk("R12 array_mode", 32'(array_mode), 1);

    // R7 array reads, sizes, erase-setup mode; R11 upper address bits dropped
    rd(24'h00_1234, 2'd0, 8'h00, 1);
    rd(24'h00_1235, 2'd1, 8'h00, 1);
    rd(24'hAB_FFFE, 2'd2, 8'h00, 1);
    rd(24'h12_0451, 2'd3, 8'h80, 1);
    idle_cyc(2);
    @(negedge clk);
    chk("R13 hold", rd_data, arr_word(16'h0451, 2'd3));

    // R2 R1 autoselect identifiers; 0x300 maps to index 0
    rd(24'h000000, 2'd1, 8'h90, 1);
    rd(24'h000002, 2'd1, 8'h90, 1);
    rd(24'h000004, 2'd1, 8'h90, 1);
    rd(24'h000300, 2'd1, 8'h90, 1);
    rd(24'h000003, 2'd1, 8'h90, 1);
    // R3 identifiers 2/3 and fallback
    rd(24'h00001C, 2'd1, 8'h90, 1);
    rd(24'h00001E, 2'd1, 8'h90, 1);
    @(posedge clk); #1 id2 = 16'h00FF; rd_en = 0;
    rd(24'h00001C, 2'd1, 8'h90, 1);
    rd(24'h00001E, 2'd1, 8'h90, 1);
    @(posedge clk); #1 id3 = 16'h00FF; id2 = 16'hFF00; rd_en = 0;
    rd(24'h00001E, 2'd2, 8'h90, 1);
    rd(24'h00001C, 2'd1, 8'h90, 1);
    // R4 other indices
    rd(24'h000006, 2'd2, 8'h90, 1);
    rd(24'h0000FE, 2'd0, 8'h90, 1);

    // R5 query table
    rd(24'h000020, 2'd0, 8'h98, 1);
    rd(24'h000098, 2'd0, 8'h98, 1);
    rd(24'h00009A, 2'd0, 8'h98, 1);
    rd(24'h0000FE, 2'd0, 8'h98, 1);
    rd(24'h000000, 2'd0, 8'h98, 1);

    // R6 status modes
    @(posedge clk); #1 status = 8'h80; rd_en = 0;
    rd(24'h000010, 2'd2, 8'h10, 0);
    @(posedge clk); #1 status = 8'h4C; rd_en = 0;
    rd(24'h000011, 2'd2, 8'h30, 0);
    @(posedge clk); #1 status = 8'h3F; rd_en = 0;
    rd(24'h000012, 2'd0, 8'hA0, 0);

    // R8 unknown mode
    rd(24'h000777, 2'd2, 8'h55, 1);
    rd(24'h000778, 2'd1, 8'hFF, 1);
    idle_cyc(1);

    // R10 write with busy decoder keeps array mode; idle write leaves it
    wr(0);
    idle_cyc(1);
    wr(1);
    idle_cyc(1);
    @(negedge clk);
    chk("R10 left array mode", 32'(array_mode), 0);

    // R9 busy-decoder reads not counted; R10 mid-count write restarts
    for (int i = 0; i < 20; i++) rd(24'(i * 4), 2'd2, 8'h00, 1);
    for (int i = 0; i < 30; i++) rd(24'(i * 4), 2'd2, 8'h00, 0);
    wr(0);
    for (int i = 0; i < LIMIT; i++) rd(24'(i), 2'd0, 8'h00, 1);
    idle_cyc(1);
    @(negedge clk);
    chk("R9 still out after limit reads", 32'(array_mode), 0);
    rd(24'h000100, 2'd0, 8'h00, 1);
    idle_cyc(1);
    @(negedge clk);
    chk("R9 re-entered on 43rd read", 32'(array_mode), 1);

    // R10 write and read in the same cycle: write wins
    @(posedge clk); #1;
    rd_en = 1; wr_seen = 1; cmd_idle = 1; cmd_mode = 8'h00; rd_addr = 24'h000040;
    idle_cyc(2);
    @(negedge clk);
    chk("R10 write priority", 32'(array_mode), 0);

    idle_cyc(3);
    done = 1;
    summary();
    $finish;
  end
endmodule